// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Dual Alternate Functions

This block controls an eight-pin general-purpose port. Software reaches it through a byte-wide register bus with an address, a write strobe, write data and read data. Six writable registers hold the per-pin output value, the output direction, the alternate-mode enable, the alternate-function choice, the fast-slew setting and the weak pull-up request. A seventh address returns the pin levels after a two-flop synchronizer. Every pin is handled on its own, so any mix of GPIO and alternate pins is allowed.

Each pin can run in one of two alternate modes, and each mode has its own peripheral output/enable pair. The alternate-function choice bit for a pin only matters when that pin's alternate enable bit is set. Otherwise the pin follows its GPIO data and direction bits. The fast-slew bit drives the slew control in both GPIO and alternate modes. Open-drain use needs no extra logic: software holds the data bit at 0 and toggles the direction bit. The pull-up output is asserted only while the pin is not driving.

The register bus is plain control access. A write takes effect at the clock edge where the strobe is sampled. Read data is combinational from the address. The bus never stalls, so there is no back-pressure; the peripheral pairs and pad signals are plain level signals with no handshake.

Top module: `gpio_alt_port`

## Requirements
- R1: Register addresses are as follows. 0 is data-out, 1 is direction, 2 is alternate enable, 3 is alternate choice, 4 is fast slew and 5 is pull-up; each reads back the last value written. Address 6 reads the synchronized pins and ignores writes. Address 7 reads 0.
- R2: Synchronous active-high reset clears all six writable registers, so every pin comes up as a non-pulled, slow-slew GPIO input (pad_oe, pad_fast and pad_pull all 0).
- R3: A pin whose alternate enable bit is 0 drives pad_out from its data-out bit and pad_oe from its direction bit.
- R4: A pin whose alternate enable bit is 1 takes pad_out and pad_oe from pair A (fn_a_out/fn_a_oe) when its choice bit is 0, and from pair B (fn_b_out/fn_b_oe) when its choice bit is 1.
- R5: The choice bit of a pin whose alternate enable bit is 0 has no effect on pad_out or pad_oe.
- R6: pad_fast equals the fast-slew register, bit for bit, in both GPIO and alternate modes. Bit value 1 selects fast slew and 0 selects slow slew.
- R7: Open-drain use works as follows. With a data-out bit of 0 in GPIO mode, setting the direction bit drives 0 with pad_oe high, and clearing it leaves the pin undriven (pad_oe low).
- R8: pad_pull for a pin is its pull-up bit ANDed with the inverse of that pin's pad_oe.
- R9: A level on pad_in sampled at clock edge k shows on pin_sync and at read address 6 after edge k+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| fn_a_out | input | 8 | Alternate pair A output value, per pin |
| fn_a_oe | input | 8 | Alternate pair A output enable, per pin |
| fn_b_out | input | 8 | Alternate pair B output value, per pin |
| fn_b_oe | input | 8 | Alternate pair B output enable, per pin |
| pad_in | input | 8 | Raw pin levels |
| pad_out | output | 8 | Output value to the pads |
| pad_oe | output | 8 | Output enable to the pads |
| pad_fast | output | 8 | Fast slew select (1 = fast) |
| pad_pull | output | 8 | Weak pull-up enable |
| pin_sync | output | 8 | Synchronized pin levels |

## Verification
The assertions check the following on every cycle:
- pull-up and output enable are never both high on the same pin;
- pin_sync is pad_in delayed by exactly two edges;
- reset leaves outputs quiet;
- a fast-slew write lands on pad_fast;
- a direction write in all-GPIO mode lands on pad_oe;
- a choice-register write while no pin is in alternate mode leaves pad_out and pad_oe unchanged.

Only the bench scenarios show the pair A and pair B routing for mixed enable and choice patterns, slew control on pins that are in alternate mode, the open-drain sequence, the read-back map and the one-edge point at which a new pin level is still hidden.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DOUT   = 3'd0,
    RA_DIR    = 3'd1,
    RA_ALT_ON = 3'd2,
    RA_ALT_B  = 3'd3,
    RA_FAST   = 3'd4,
    RA_PULL   = 3'd5,
    RA_PINS   = 3'd6,
    RA_NONE   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else if (s == 0) chain[s] <= raw;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_alt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pins,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  dout_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  alt_on_q,
  output logic [WIDTH-1:0]  alt_b_q,
  output logic [WIDTH-1:0]  fast_q,
  output logic [WIDTH-1:0]  pull_q
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      dir_q    <= '0;
      alt_on_q <= '0;
      alt_b_q  <= '0;
      fast_q   <= '0;
      pull_q   <= '0;
    end else if (wr) begin
      case (sel)
        RA_DOUT:   dout_q   <= wdata;
        RA_DIR:    dir_q    <= wdata;
        RA_ALT_ON: alt_on_q <= wdata;
        RA_ALT_B:  alt_b_q  <= wdata;
        RA_FAST:   fast_q   <= wdata;
        RA_PULL:   pull_q   <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RA_DOUT:   rdata = dout_q;
      RA_DIR:    rdata = dir_q;
      RA_ALT_ON: rdata = alt_on_q;
      RA_ALT_B:  rdata = alt_b_q;
      RA_FAST:   rdata = fast_q;
      RA_PULL:   rdata = pull_q;
      RA_PINS:   rdata = pins;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
  input  logic gp_out,
  input  logic gp_oe,
  input  logic alt_on,
  input  logic alt_b,
  input  logic a_out,
  input  logic a_oe,
  input  logic b_out,
  input  logic b_oe,
  input  logic fast_req,
  input  logic pull_req,
  output logic pin_out,
  output logic pin_oe,
  output logic pin_fast,
  output logic pin_pull
);
  always_comb begin
    if (!alt_on) begin
      pin_out = gp_out;
      pin_oe  = gp_oe;
    end else if (alt_b) begin
      pin_out = b_out;
      pin_oe  = b_oe;
    end else begin
      pin_out = a_out;
      pin_oe  = a_oe;
    end
    pin_fast = fast_req;
    pin_pull = pull_req & ~pin_oe;
  end
endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
  import gpio_alt_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  fn_a_out,
  input  logic [NPINS-1:0]  fn_a_oe,
  input  logic [NPINS-1:0]  fn_b_out,
  input  logic [NPINS-1:0]  fn_b_oe,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_fast,
  output logic [NPINS-1:0]  pad_pull,
  output logic [NPINS-1:0]  pin_sync
);
  logic [NPINS-1:0] dout_q, dir_q, alt_on_q, alt_b_q, fast_q, pull_q;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    (pad_in),
    .synced (pin_sync)
  );

  gpio_regs #(.WIDTH(NPINS)) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .pins     (pin_sync),
    .rdata    (bus_rdata),
    .dout_q   (dout_q),
    .dir_q    (dir_q),
    .alt_on_q (alt_on_q),
    .alt_b_q  (alt_b_q),
    .fast_q   (fast_q),
    .pull_q   (pull_q)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_mux i_mux (
      .gp_out   (dout_q[p]),
      .gp_oe    (dir_q[p]),
      .alt_on   (alt_on_q[p]),
      .alt_b    (alt_b_q[p]),
      .a_out    (fn_a_out[p]),
      .a_oe     (fn_a_oe[p]),
      .b_out    (fn_b_out[p]),
      .b_oe     (fn_b_oe[p]),
      .fast_req (fast_q[p]),
      .pull_req (pull_q[p]),
      .pin_out  (pad_out[p]),
      .pin_oe   (pad_oe[p]),
      .pin_fast (pad_fast[p]),
      .pin_pull (pad_pull[p])
    );
  end
endmodule

// File: rtl/gpio_alt_port_chk.sv
module gpio_alt_port_chk
  import gpio_alt_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  alt_on_q,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_fast,
  input logic [NPINS-1:0]  pad_pull,
  input logic [NPINS-1:0]  pin_sync
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_fast == '0 && pad_pull == '0));

  // R8
  pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_pull & pad_oe) == '0);

  // R9
  sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> pin_sync == $past(pad_in, 2));

  // R6
  fast_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_FAST) |=> pad_fast == $past(bus_wdata));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_DIR && alt_on_q == '0) |=> pad_oe == $past(bus_wdata));

  // R5
  choice_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == RA_ALT_B && alt_on_q == '0) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_alt_port gpio_alt_port_chk #(.NPINS(NPINS)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .alt_on_q  (alt_on_q),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_fast  (pad_fast),
  .pad_pull  (pad_pull),
  .pin_sync  (pin_sync)
);

// File: tb/test_gpio_alt_port.sv
module test_gpio_alt_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] fn_a_out = 8'h0F, fn_a_oe = 8'hFF, fn_b_out = 8'hF0, fn_b_oe = 8'h33;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_fast, pad_pull, pin_sync;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int         what;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];
  event  kick;

  always #2.5 clk = ~clk;

  gpio_alt_port i_gpio_alt_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fn_a_out(fn_a_out), .fn_a_oe(fn_a_oe), .fn_b_out(fn_b_out), .fn_b_oe(fn_b_oe),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_fast(pad_fast),
    .pad_pull(pad_pull), .pin_sync(pin_sync)
  );

  // monitor: pops expected items and compares with the observed signal
  initial begin
    forever begin
      @(kick);
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb.pop_front();
        case (it.what)
          0: got = bus_rdata;
          1: got = pad_out;
          2: got = pad_oe;
          3: got = pad_fast;
          4: got = pad_pull;
          default: got = pin_sync;
        endcase
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int what, input logic [7:0] exp, input string tag);
    item_t it;
    it.what = what; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    ->kick;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    expect_item(0, exp, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R2 reset state
    expect_item(2, 8'h00, "R2 oe");
    expect_item(3, 8'h00, "R2 fast");
    expect_item(4, 8'h00, "R2 pull");
    for (int a = 0; a < 6; a++) rd(a[2:0], 8'h00, "R2 reg clear");

    // R3 GPIO mode
    wr(3'd0, 8'hA5);
    wr(3'd1, 8'h3C);
    expect_item(1, 8'hA5, "R3 out");
    expect_item(2, 8'h3C, "R3 oe");
    rd(3'd0, 8'hA5, "R1 dout readback");
    rd(3'd1, 8'h3C, "R1 dir readback");

    // R5 choice ignored while alternate mode is off
    wr(3'd3, 8'hFF);
    expect_item(1, 8'hA5, "R5 out");
    expect_item(2, 8'h3C, "R5 oe");
    rd(3'd3, 8'hFF, "R1 choice readback");

    // R4 low nibble alternate, all pair B
    wr(3'd2, 8'h0F);
    expect_item(1, 8'hA0, "R4 pair B out");
    expect_item(2, 8'h33, "R4 pair B oe");
    rd(3'd2, 8'h0F, "R1 enable readback");

    // R4 mixed pairs: pins 0,2 on B, pins 1,3 on A
    wr(3'd3, 8'h05);
    expect_item(1, 8'hAA, "R4 mixed out");
    expect_item(2, 8'h3B, "R4 mixed oe");

    // R6 slew on an alternate pin (0) and a GPIO pin (7)
    wr(3'd4, 8'h81);
    expect_item(3, 8'h81, "R6 fast both modes");
    rd(3'd4, 8'h81, "R1 fast readback");

    // R8 pull-up only where not driving
    wr(3'd5, 8'hFF);
    expect_item(4, 8'hC4, "R8 pull");
    rd(3'd5, 8'hFF, "R1 pull readback");

    // R7 open-drain sequence
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    expect_item(2, 8'h00, "R7 released oe");
    expect_item(4, 8'hFF, "R7 released pull");
    wr(3'd1, 8'h55);
    expect_item(2, 8'h55, "R7 driving oe");
    expect_item(1, 8'h00, "R7 driving out");
    expect_item(4, 8'hAA, "R7 pull on released pins");

    // R1 pin address ignores writes, address 7 reads zero
    wr(3'd6, 8'hFF);
    rd(3'd6, 8'h00, "R1 pins read only");
    rd(3'd7, 8'h00, "R1 unused address");

    // R9 synchronizer latency
    @(negedge clk);
    pad_in = 8'h6C;
    @(negedge clk);
    #1;
    expect_item(5, 8'h00, "R9 hidden after one edge");
    rd(3'd6, 8'h00, "R9 read hidden");
    @(negedge clk);
    #1;
    expect_item(5, 8'h6C, "R9 visible after two edges");
    rd(3'd6, 8'h6C, "R9 read visible");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule